// File: doc/BRIEF.md
# Low-Power DDR SDRAM Power-Up Command Sequencer

This block sits on the controller side of a low-power double-data-rate SDRAM and runs the power-up sequence the memory needs before it can be used. After reset it leaves the command bus deselected with the clock enable low. When `start_i` is seen, it raises the clock enable and keeps it high. It then places only NOP on the bus for a configurable settling time. Next it issues a precharge of all banks and two auto-refresh commands. It then loads the mode register and the extended mode register, and finally raises a sticky done flag. Every command is followed by a configurable number of NOP cycles.

All waits are counted in clock cycles. The integrator sets them from the clock period: `T_INIT` covers the 200 µs settling time, and `T_RP`, `T_RFC` and `T_MRD` cover the precharge, refresh and mode-load recovery times. The parameter `LATE_REF2` moves the second refresh and its gap so that it runs between the two mode-register loads. The memory has no DLL, so the sequence contains no DLL step. A reset at any point aborts the sequence, and the next start runs it again from the settling wait.

Top module: `mddr_init_seq`

## Requirements
- R1: While reset is asserted, and in idle before a start, `cke_o` is 0, `cs_n_o` is 1 (deselect) and `init_done_o` is 0.
- R2: From the clock edge that samples `start_i` high in idle, `cke_o` is 1, and it stays 1 until reset.
- R3: The first T_INIT cycles after that edge carry NOP (`{cs_n,ras_n,cas_n,we_n}` = 0111, address 0). The next cycle carries PRECHARGE ALL: 0010 with address bit 10 = 1 and all other address bits 0.
- R4: PRECHARGE ALL is followed by exactly T_RP NOP cycles, and then by the first AUTO REFRESH (0001, address 0, bank 0).
- R5: Each AUTO REFRESH is followed by exactly T_RFC NOP cycles, and the sequence contains exactly two refreshes.
- R6: LOAD MODE REGISTER is 0000 with bank 00 and address = MR_OPCODE. LOAD EXTENDED MODE REGISTER is 0000 with bank 10 and address = EMR_OPCODE. Each is followed by exactly T_MRD NOP cycles.
- R7: With LATE_REF2 = 0 the commands run in the order PRE, REF, REF, LMR, EMR. With LATE_REF2 = 1 they run in the order PRE, REF, LMR, REF, EMR.
- R8: `init_done_o` rises in the cycle after the last T_MRD gap and stays high until reset. From then on the bus carries NOP and `start_i` has no effect.
- R9: A reset asserted in any cycle of the sequence returns the block to the idle state of R1. The next start then runs the whole sequence again from the T_INIT wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins the sequence when sampled high in idle |
| cke_o | output | 1 | Memory clock enable |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | 2 | Bank address (selects the mode register for loads) |
| addr_o | output | ADDR_W | Address bus; bit 10 selects all banks on precharge |
| init_done_o | output | 1 | Sequence complete, sticky |

## Verification
The assertions check, on every cycle, the properties that hold locally:
- the clock enable and the done flag never fall;
- a deselected bus whenever the clock enable is low;
- the all-banks bit on every precharge;
- a NOP directly after every command;
- a gap counter that stays below its limit.

Only the bench's scenarios can show the cycle position of each command, the exact gap lengths, the two command orders, the count of refreshes, and the restart after a reset. It shows these by comparing complete traces of both variants against positions computed from the wait parameters, with a reset injected at every cycle of the sequence in turn.

// File: rtl/mddr_init_pkg.sv
package mddr_init_pkg;

    // Command kinds placed on the memory bus.
    typedef enum logic [2:0] {
        K_DES = 3'd0,
        K_NOP = 3'd1,
        K_PRE = 3'd2,
        K_REF = 3'd3,
        K_LMR = 3'd4,
        K_EMR = 3'd5
    } cmd_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_GAP  = 2'd1,
        ST_CMD  = 2'd2,
        ST_DONE = 2'd3
    } seq_state_e;

    // Executable commands issued after the settling wait.
    localparam int NUM_STEPS = 5;

endpackage

// File: rtl/mddr_init_order.sv
module mddr_init_order
    import mddr_init_pkg::*;
#(
    parameter bit LATE_REF2 = 1'b0
) (
    input  logic [2:0] step_i,
    output cmd_kind_e  kind_o
);

    generate
        if (LATE_REF2) begin : g_late
            // PRE, REF, LMR, REF, EMR
            always_comb begin
                case (step_i)
                    3'd0:    kind_o = K_PRE;
                    3'd1:    kind_o = K_REF;
                    3'd2:    kind_o = K_LMR;
                    3'd3:    kind_o = K_REF;
                    3'd4:    kind_o = K_EMR;
                    default: kind_o = K_NOP;
                endcase
            end
        end else begin : g_early
            // PRE, REF, REF, LMR, EMR
            always_comb begin
                case (step_i)
                    3'd0:    kind_o = K_PRE;
                    3'd1:    kind_o = K_REF;
                    3'd2:    kind_o = K_REF;
                    3'd3:    kind_o = K_LMR;
                    3'd4:    kind_o = K_EMR;
                    default: kind_o = K_NOP;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/mddr_init_encode.sv
module mddr_init_encode
    import mddr_init_pkg::*;
#(
    parameter int          ADDR_W     = 13,
    parameter logic [31:0] MR_OPCODE  = 32'h0000_0032,
    parameter logic [31:0] EMR_OPCODE = 32'h0000_0000
) (
    input  cmd_kind_e          kind_i,
    output logic               cs_n_o,
    output logic               ras_n_o,
    output logic               cas_n_o,
    output logic               we_n_o,
    output logic [1:0]         ba_o,
    output logic [ADDR_W-1:0]  addr_o
);

    localparam int ALL_BANK_BIT = 10;

    always_comb begin
        cs_n_o  = 1'b0;
        ras_n_o = 1'b1;
        cas_n_o = 1'b1;
        we_n_o  = 1'b1;
        ba_o    = 2'b00;
        addr_o  = '0;
        case (kind_i)
            K_DES: cs_n_o = 1'b1;
            K_PRE: begin
                ras_n_o = 1'b0;
                we_n_o  = 1'b0;
                addr_o[ALL_BANK_BIT] = 1'b1;
            end
            K_REF: begin
                ras_n_o = 1'b0;
                cas_n_o = 1'b0;
            end
            K_LMR: begin
                ras_n_o = 1'b0;
                cas_n_o = 1'b0;
                we_n_o  = 1'b0;
                addr_o  = MR_OPCODE[ADDR_W-1:0];
            end
            K_EMR: begin
                ras_n_o = 1'b0;
                cas_n_o = 1'b0;
                we_n_o  = 1'b0;
                ba_o    = 2'b10;
                addr_o  = EMR_OPCODE[ADDR_W-1:0];
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/mddr_init_seq.sv
module mddr_init_seq
    import mddr_init_pkg::*;
#(
    parameter int          T_INIT     = 20800,
    parameter int          T_RP       = 3,
    parameter int          T_RFC      = 8,
    parameter int          T_MRD      = 2,
    parameter bit          LATE_REF2  = 1'b0,
    parameter int          ADDR_W     = 13,
    parameter logic [31:0] MR_OPCODE  = 32'h0000_0032,
    parameter logic [31:0] EMR_OPCODE = 32'h0000_0000
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    output logic              cke_o,
    output logic              cs_n_o,
    output logic              ras_n_o,
    output logic              cas_n_o,
    output logic              we_n_o,
    output logic [1:0]        ba_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              init_done_o
);

    localparam int MAX_A = (T_RP > T_RFC) ? T_RP : T_RFC;
    localparam int MAX_B = (MAX_A > T_MRD) ? MAX_A : T_MRD;
    localparam int MAX_T = (MAX_B > T_INIT) ? MAX_B : T_INIT;
    localparam int CNT_W = $clog2(MAX_T + 1);

    typedef struct packed {
        seq_state_e       st;
        logic [2:0]       step;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] lim;
        cmd_kind_e        kind;
        logic             cke;
        logic             done;
    } regs_t;

    regs_t     seq_d, seq_q;
    cmd_kind_e step_kind;

    initial begin
        assert (T_INIT >= 1 && T_RP >= 1 && T_RFC >= 1 && T_MRD >= 1)
            else $error("wait parameters must be at least one cycle");
        assert (ADDR_W >= 11) else $error("address bus needs bit 10");
    end

    function automatic logic [CNT_W-1:0] gap_of(cmd_kind_e k);
        case (k)
            K_PRE:   gap_of = CNT_W'(T_RP);
            K_REF:   gap_of = CNT_W'(T_RFC);
            default: gap_of = CNT_W'(T_MRD);
        endcase
    endfunction

    mddr_init_order #(
        .LATE_REF2 (LATE_REF2)
    ) u_order (
        .step_i (seq_q.step),
        .kind_o (step_kind)
    );

    always_comb begin
        seq_d = seq_q;
        case (seq_q.st)
            ST_IDLE: begin
                seq_d.kind = K_DES;
                seq_d.cke  = 1'b0;
                if (start_i) begin
                    seq_d.st   = ST_GAP;
                    seq_d.cke  = 1'b1;
                    seq_d.kind = K_NOP;
                    seq_d.cnt  = '0;
                    seq_d.lim  = CNT_W'(T_INIT);
                    seq_d.step = '0;
                end
            end
            ST_GAP: begin
                seq_d.kind = K_NOP;
                if (seq_q.cnt == seq_q.lim - CNT_W'(1)) begin
                    seq_d.cnt = '0;
                    if (seq_q.step == 3'(NUM_STEPS)) begin
                        seq_d.st   = ST_DONE;
                        seq_d.done = 1'b1;
                    end else begin
                        seq_d.st   = ST_CMD;
                        seq_d.kind = step_kind;
                    end
                end else begin
                    seq_d.cnt = seq_q.cnt + CNT_W'(1);
                end
            end
            ST_CMD: begin
                seq_d.st   = ST_GAP;
                seq_d.kind = K_NOP;
                seq_d.lim  = gap_of(seq_q.kind);
                seq_d.step = seq_q.step + 3'd1;
            end
            default: seq_d.kind = K_NOP;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q <= '{st: ST_IDLE, step: '0, cnt: '0, lim: '0,
                       kind: K_DES, cke: 1'b0, done: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    mddr_init_encode #(
        .ADDR_W     (ADDR_W),
        .MR_OPCODE  (MR_OPCODE),
        .EMR_OPCODE (EMR_OPCODE)
    ) u_encode (
        .kind_i  (seq_q.kind),
        .cs_n_o  (cs_n_o),
        .ras_n_o (ras_n_o),
        .cas_n_o (cas_n_o),
        .we_n_o  (we_n_o),
        .ba_o    (ba_o),
        .addr_o  (addr_o)
    );

    assign cke_o       = seq_q.cke;
    assign init_done_o = seq_q.done;

    // ---------------- assertions ----------------
    assert_idle_deselect_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cke_o |-> (cs_n_o && !init_done_o));

    assert_cke_held_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cke_o |=> cke_o);

    assert_pre_all_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cs_n_o && !ras_n_o && cas_n_o && !we_n_o) |-> addr_o[10]);

    assert_cmd_then_nop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_q.st == ST_CMD) |=> (!cs_n_o && ras_n_o && cas_n_o && we_n_o));

    assert_gap_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_q.st == ST_GAP) |-> (seq_q.cnt < seq_q.lim));

    assert_done_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        init_done_o |=> (init_done_o && cke_o));

endmodule

// File: tb/tb_mddr_init_seq.sv
module tb_mddr_init_seq;

    localparam int TI   = 5;
    localparam int TRP  = 2;
    localparam int TRFC = 3;
    localparam int TMRD = 2;
    localparam int AW   = 13;
    localparam logic [31:0] MRV  = 32'h0000_0032;
    localparam logic [31:0] EMRV = 32'h0000_0020;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    int   checks = 0;
    int   errors = 0;

    logic          cke   [2];
    logic          cs_n  [2];
    logic          ras_n [2];
    logic          cas_n [2];
    logic          we_n  [2];
    logic [1:0]    ba    [2];
    logic [AW-1:0] addr  [2];
    logic          done  [2];

    always #10 clk = ~clk;

    mddr_init_seq #(.T_INIT(TI), .T_RP(TRP), .T_RFC(TRFC), .T_MRD(TMRD),
        .LATE_REF2(1'b0), .ADDR_W(AW), .MR_OPCODE(MRV), .EMR_OPCODE(EMRV)) dut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cke_o(cke[0]),
        .cs_n_o(cs_n[0]), .ras_n_o(ras_n[0]), .cas_n_o(cas_n[0]), .we_n_o(we_n[0]),
        .ba_o(ba[0]), .addr_o(addr[0]), .init_done_o(done[0]));

    mddr_init_seq #(.T_INIT(TI), .T_RP(TRP), .T_RFC(TRFC), .T_MRD(TMRD),
        .LATE_REF2(1'b1), .ADDR_W(AW), .MR_OPCODE(MRV), .EMR_OPCODE(EMRV)) dut_late (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cke_o(cke[1]),
        .cs_n_o(cs_n[1]), .ras_n_o(ras_n[1]), .cas_n_o(cas_n[1]), .we_n_o(we_n[1]),
        .ba_o(ba[1]), .addr_o(addr[1]), .init_done_o(done[1]));

    // kinds: 0 NOP, 1 PRE, 2 REF, 3 LMR, 4 EMR
    function automatic int kind_at(int late, int s);
        case (s)
            0: return 1;
            1: return 2;
            2: return late ? 3 : 2;
            3: return late ? 2 : 3;
            default: return 4;
        endcase
    endfunction

    function automatic int gap_of(int k);
        if (k == 1) return TRP;
        if (k == 2) return TRFC;
        return TMRD;
    endfunction

    function automatic int pos_of(int late, int s);
        int p = TI;
        for (int j = 0; j < s; j++) p += 1 + gap_of(kind_at(late, j));
        return p;
    endfunction

    function automatic int exp_kind(int late, int i);
        for (int s = 0; s < 5; s++) if (i == pos_of(late, s)) return kind_at(late, s);
        return 0;
    endfunction

    // Packed observation: {cke, cs, ras, cas, we, ba, addr, done}
    function automatic logic [AW+7:0] exp_vec(int late, int i);
        int k = exp_kind(late, i);
        logic [3:0] c = 4'b0111;
        logic [1:0] b = 2'b00;
        logic [AW-1:0] a = '0;
        case (k)
            1: begin c = 4'b0010; a[10] = 1'b1; end
            2: c = 4'b0001;
            3: begin c = 4'b0000; a = MRV[AW-1:0]; end
            4: begin c = 4'b0000; b = 2'b10; a = EMRV[AW-1:0]; end
            default: ;
        endcase
        return {1'b1, c, b, a, (i >= pos_of(late, 5))};
    endfunction

    function automatic logic [AW+7:0] obs_vec(int u);
        return {cke[u], cs_n[u], ras_n[u], cas_n[u], we_n[u], ba[u], addr[u], done[u]};
    endfunction

    function automatic string tag_of(int late, int i);
        int k = exp_kind(late, i);
        if (late != 0) return "R7";
        if (i >= pos_of(0, 5)) return "R8";
        if (k == 1 || i < TI) return "R3";
        if (k == 2) return "R5";
        if (k >= 3) return "R6";
        return "R4";
    endfunction

    task automatic check(string tag, logic [AW+7:0] act, logic [AW+7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_idle(string tag);
        for (int u = 0; u < 2; u++)
            check(tag, {cke[u], cs_n[u], done[u]}, {1'b0, 1'b1, 1'b0});
    endtask

    // Pulse start and compare full traces of both variants.
    task automatic run_full(string rtag);
        int refs [2];
        int last = pos_of(0, 5) + 3;
        refs[0] = 0;
        refs[1] = 0;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i <= last; i++) begin
            for (int u = 0; u < 2; u++) begin
                check((i == 0) ? "R2" : ((rtag != "") ? rtag : tag_of(u, i)),
                      obs_vec(u), exp_vec(u, i));
                if (!cs_n[u] && !ras_n[u] && !cas_n[u] && we_n[u]) refs[u]++;
            end
            @(negedge clk);
        end
        for (int u = 0; u < 2; u++) check("R5", 32'(refs[u]), 32'd2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        check_idle("R1");
        @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check_idle("R1");

        run_full("");

        // R8: start after completion has no effect
        start = 1'b1;
        repeat (2) @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        for (int u = 0; u < 2; u++)
            check("R8", obs_vec(u), exp_vec(u, pos_of(u, 5) + 5));

        // R9: reset injected at every cycle of the sequence
        for (int r = 0; r <= pos_of(0, 5); r++) begin
            rst_n = 1'b0;
            @(negedge clk);
            rst_n = 1'b1;
            @(negedge clk);
            start = 1'b1;
            @(posedge clk);
            @(negedge clk);
            start = 1'b0;
            repeat (r) @(negedge clk);
            rst_n = 1'b0;
            #1;
            check_idle("R9");
            @(negedge clk);
            rst_n = 1'b1;
            @(negedge clk);
            check_idle("R9");
            run_full("R9");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule